// File: doc/BRIEF.md
# Dynamic 16/32-Bit Bus Sizing Sequencer

This block sits between a 32-bit processor-side request port and an external bus whose targets may be 16 bits wide. A request carries four active-low byte enables, a direction flag and 32 bits of write data. The sequencer drives the external byte enables and write data. On the edge that ends each bus cycle it samples a ready input and a narrow-target input. From the byte-enable pattern and the narrow indication it decides whether to finish in one cycle with data in its natural lanes, to steer the upper bytes of a read from the low lanes, or to split the transfer into two 16-bit cycles.

Write data for the upper half is copied onto the low lanes whenever a 16-bit target might need it. Read data comes back as one assembled 32-bit word, together with a one-clock done strobe. For split writes the block checks that the target reported itself narrow again in the second cycle, and raises a protocol-error flag if it did not.

Top module: `busSizer`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) no bus cycle is active, `busCycle` and `doneStrobe` are 0 and `busBeN` is 4'b1111.
- R2: A request is accepted only while idle: `reqValid` sampled at an edge in idle starts a bus cycle, visible after that edge with `busBeN` equal to `reqBeN`. `reqValid` while a transfer is in progress is ignored and starts no further cycle.
- R3: A bus cycle ends only at an edge where `busRdy` is 1. While `busRdy` is 0, `busBeN` and `busWdata` stay unchanged.
- R4: A transfer that enables only bytes 0 and/or 1 (`busBeN[3:2]`=2'b11) completes in one cycle with data in natural lanes, whatever `busNarrow` says.
- R5: A read that enables only bytes 2 and/or 3 completes in one cycle. If `busNarrow` is 1 at completion, `rdData` = {`busRdata[15:0]`, 16'h0000}, so byte 2 comes from bits 7:0 and byte 3 from bits 15:8. Otherwise `rdData` = `busRdata`.
- R6: A write that enables only bytes 2 and/or 3 drives `busWdata` = {`reqWdata[31:16]`, `reqWdata[31:16]`} and completes in one cycle regardless of `busNarrow`.
- R7: A transfer that enables bytes in both halves, completing with `busNarrow`=0, takes one cycle with natural lanes (`rdData` = `busRdata`, `busWdata` = `reqWdata`).
- R8: A read enabling bytes in both halves that completes with `busNarrow`=1 runs a second cycle. The result is {second `busRdata[15:0]`, first `busRdata[15:0]`}, and bits 31:16 are ignored in both cycles.
- R9: In the second cycle of a split transfer `busBeN` = {original `reqBeN[3:2]`, 2'b11}.
- R10: For a split write the first cycle drives `busWdata` = `reqWdata`. The second drives {`reqWdata[31:16]`, `reqWdata[31:16]`}.
- R11: `protoErr` is 1 alongside `doneStrobe` exactly when the second cycle of a split write completed with `busNarrow`=0. It is cleared when a new request is accepted.
- R12: `doneStrobe` is 1 for exactly one clock, directly after the edge that completes the final cycle. `rdData` and `protoErr` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present (taken only when idle) |
| reqBeN | input | 4 | Requested byte enables, active low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data in natural lanes |
| busCycle | output | 1 | External bus cycle in progress |
| busWrite | output | 1 | Direction of the current bus cycle |
| busBeN | output | 4 | External byte enables, active low |
| busWdata | output | 32 | External write data |
| busRdata | input | 32 | External read data |
| busRdy | input | 1 | Current bus cycle completes at this edge |
| busNarrow | input | 1 | Addressed target is 16 bits wide |
| rdData | output | 32 | Assembled read data |
| doneStrobe | output | 1 | Transfer finished (one clock) |
| protoErr | output | 1 | Split write second cycle missed the narrow indication |

## Verification
The bench aims at the byte-enable patterns on either side of the split decision. Reads of bytes 1 and 2 must split. Low-only transfers must not, even when the target reports itself narrow. A design that split on any narrow indication would add a cycle, and one that checked only byte 0 would miss the case that straddles the halves. Steered upper-only reads catch a lane swap or reads taken from bits 31:16. Split writes with and without a repeated narrow indication expose a missing duplication or a missing error flag. The bench also holds wait states to catch outputs that drift before ready, and pulses a request mid-transfer to catch a sequencer that accepts it.

// File: rtl/busSizerPkg.sv
package busSizerPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC1 = 2'd1,
    ST_CYC2 = 2'd2,
    ST_FIN  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic active;
    logic phase2;
    logic capNatural;
    logic capSteer;
    logic capLow;
    logic capHigh;
    logic setErr;
  } ctrlStrobes_t;

endpackage

// File: rtl/busSizerCtrl.sv
module busSizerCtrl
  import busSizerPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         busRdy,
  input  logic         busNarrow,
  input  logic         lowOn,
  input  logic         highOn,
  input  logic         isWrite,
  output ctrlStrobes_t strb,
  output logic         doneStrobe
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          nextState    = ST_CYC1;
        end
      end
      ST_CYC1: begin
        strb.active = 1'b1;
        if (busRdy) begin
          if (busNarrow && lowOn && highOn) begin
            nextState   = ST_CYC2;
            strb.capLow = !isWrite;
          end else begin
            nextState = ST_FIN;
            if (!isWrite) begin
              if (busNarrow && highOn && !lowOn) strb.capSteer   = 1'b1;
              else                               strb.capNatural = 1'b1;
            end
          end
        end
      end
      ST_CYC2: begin
        strb.active = 1'b1;
        strb.phase2 = 1'b1;
        if (busRdy) begin
          nextState    = ST_FIN;
          strb.capHigh = !isWrite;
          strb.setErr  = isWrite && !busNarrow;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign doneStrobe = (state == ST_FIN);

  // R12: done lasts one clock
  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    doneStrobe |=> !doneStrobe);

  // R3: a cycle without ready keeps its state
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CYC1 || state == ST_CYC2) && !busRdy) |=> (state == $past(state)));

  // R8: second cycle only after narrow completion of a both-halves first cycle
  a_r8_split_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CYC1 && busRdy && busNarrow && lowOn && highOn) |=> (state == ST_CYC2));

  // R2: no acceptance outside idle
  a_r2_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !strb.loadReq);

endmodule

// File: rtl/busSizerDp.sv
module busSizerDp
  import busSizerPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W/8-1:0] reqBeN,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W/8-1:0] busBeN,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrite,
  output logic [DATA_W-1:0] rdData,
  output logic              protoErr,
  output logic              lowOn,
  output logic              highOn,
  output logic              isWrite
);

  localparam int BE_W    = DATA_W / 8;
  localparam int HALF    = DATA_W / 2;
  localparam int HALF_BE = BE_W / 2;

  logic [BE_W-1:0]   beQ;
  logic              wrQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdQ;
  logic              errQ;
  logic              dupUpper;

  always_ff @(posedge clk) begin
    if (rst) begin
      beQ  <= '1;
      wrQ  <= 1'b0;
      wdQ  <= '0;
      rdQ  <= '0;
      errQ <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        beQ  <= reqBeN;
        wrQ  <= reqWrite;
        wdQ  <= reqWdata;
        errQ <= 1'b0;
      end
      if (strb.capNatural) rdQ <= busRdata;
      if (strb.capSteer)   rdQ <= {busRdata[HALF-1:0], {HALF{1'b0}}};
      if (strb.capLow)     rdQ <= {{HALF{1'b0}}, busRdata[HALF-1:0]};
      if (strb.capHigh)    rdQ[DATA_W-1:HALF] <= busRdata[HALF-1:0];
      if (strb.setErr)     errQ <= 1'b1;
    end
  end

  assign lowOn   = ~&beQ[HALF_BE-1:0];
  assign highOn  = ~&beQ[BE_W-1:HALF_BE];
  assign isWrite = wrQ;

  assign dupUpper = highOn && (!lowOn || strb.phase2);

  always_comb begin
    if (!strb.active)     busBeN = '1;
    else if (strb.phase2) busBeN = {beQ[BE_W-1:HALF_BE], {HALF_BE{1'b1}}};
    else                  busBeN = beQ;
  end

  always_comb begin
    if (!strb.active) busWdata = '0;
    else if (dupUpper) busWdata = {wdQ[DATA_W-1:HALF], wdQ[DATA_W-1:HALF]};
    else               busWdata = wdQ;
  end

  assign busWrite = strb.active && wrQ;
  assign rdData   = rdQ;
  assign protoErr = errQ;

  // R6: upper-only writes carry the same half on both lane groups
  a_r6_upper_dup: assert property (@(posedge clk) disable iff (rst)
    (busWrite && !lowOn && highOn) |-> (busWdata[HALF-1:0] == busWdata[DATA_W-1:HALF]));

  // R9: low enables off in the second cycle, upper ones as requested
  a_r9_second_low_off: assert property (@(posedge clk) disable iff (rst)
    strb.phase2 |-> (&busBeN[HALF_BE-1:0] && busBeN[BE_W-1:HALF_BE] == beQ[BE_W-1:HALF_BE]));

endmodule

// File: rtl/busSizer.sv
module busSizer
  import busSizerPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [DATA_W/8-1:0] reqBeN,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                busCycle,
  output logic                busWrite,
  output logic [DATA_W/8-1:0] busBeN,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busRdy,
  input  logic                busNarrow,
  output logic [DATA_W-1:0]   rdData,
  output logic                doneStrobe,
  output logic                protoErr
);

  ctrlStrobes_t strb;
  logic lowOn, highOn, isWrite;

  busSizerCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .busRdy     (busRdy),
    .busNarrow  (busNarrow),
    .lowOn      (lowOn),
    .highOn     (highOn),
    .isWrite    (isWrite),
    .strb       (strb),
    .doneStrobe (doneStrobe)
  );

  busSizerDp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqBeN   (reqBeN),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busBeN   (busBeN),
    .busWdata (busWdata),
    .busWrite (busWrite),
    .rdData   (rdData),
    .protoErr (protoErr),
    .lowOn    (lowOn),
    .highOn   (highOn),
    .isWrite  (isWrite)
  );

  assign busCycle = strb.active;

  // R3: wait states hold the bus outputs
  a_r3_stable_wait: assert property (@(posedge clk) disable iff (rst)
    (busCycle && !busRdy) |=> ($stable(busBeN) && $stable(busWdata)));

  // R12: done only after the bus is released
  a_r12_done_no_cycle: assert property (@(posedge clk) disable iff (rst)
    doneStrobe |-> !busCycle);

endmodule

// File: tb/sim_busSizer.sv
module sim_busSizer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [3:0]  reqBeN;
  logic        reqWrite;
  logic [31:0] reqWdata;
  logic        busCycle, busWrite;
  logic [3:0]  busBeN;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        busRdy, busNarrow;
  logic [31:0] rdData;
  logic        doneStrobe, protoErr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busSizer u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqBeN(reqBeN), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .busCycle(busCycle), .busWrite(busWrite), .busBeN(busBeN),
    .busWdata(busWdata), .busRdata(busRdata), .busRdy(busRdy), .busNarrow(busNarrow),
    .rdData(rdData), .doneStrobe(doneStrobe), .protoErr(protoErr)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [3:0]  be;
    logic        wr;
    logic        n1;
    logic        n2;
    logic [1:0]  cyc;
    logic [3:0]  be2;
    logic [31:0] wd1;
    logic [31:0] wd2;
    logic [31:0] rd;
    logic        err;
  } vec_t;

  localparam logic [31:0] WD  = 32'h1122_3344;
  localparam logic [31:0] RD1 = 32'hA1B2_C3D4;
  localparam logic [31:0] RD2 = 32'h5566_7788;
  localparam int NV = 12;

  localparam vec_t VECS [NV] = '{
    '{4'd4,  4'b1100, 1'b0, 1'b1, 1'b0, 2'd1, 4'hF,    WD, 32'h0, RD1,           1'b0}, // R4 low read, narrow
    '{4'd4,  4'b1110, 1'b1, 1'b1, 1'b0, 2'd1, 4'hF,    WD, 32'h0, 32'h0,         1'b0}, // R4 low write, narrow
    '{4'd5,  4'b0011, 1'b0, 1'b1, 1'b0, 2'd1, 4'hF,    WD, 32'h0, 32'hC3D4_0000, 1'b0}, // R5 steered
    '{4'd5,  4'b0011, 1'b0, 1'b0, 1'b0, 2'd1, 4'hF,    WD, 32'h0, RD1,           1'b0}, // R5 wide
    '{4'd6,  4'b0111, 1'b1, 1'b1, 1'b0, 2'd1, 4'hF,    32'h1122_1122, 32'h0, 32'h0, 1'b0}, // R6 narrow
    '{4'd6,  4'b1011, 1'b1, 1'b0, 1'b0, 2'd1, 4'hF,    32'h1122_1122, 32'h0, 32'h0, 1'b0}, // R6 wide
    '{4'd7,  4'b0000, 1'b0, 1'b0, 1'b0, 2'd1, 4'hF,    WD, 32'h0, RD1,           1'b0}, // R7 read
    '{4'd8,  4'b0000, 1'b0, 1'b1, 1'b1, 2'd2, 4'b0011, WD, 32'h0, 32'h7788_C3D4, 1'b0}, // R8 split read
    '{4'd9,  4'b1001, 1'b0, 1'b1, 1'b1, 2'd2, 4'b1011, WD, 32'h0, 32'h7788_C3D4, 1'b0}, // R9 bytes 1,2
    '{4'd10, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd2, 4'b0011, WD, 32'h1122_1122, 32'h0, 1'b0}, // R10 split write
    '{4'd11, 4'b0000, 1'b1, 1'b1, 1'b0, 2'd2, 4'b0011, WD, 32'h1122_1122, 32'h0, 1'b1}, // R11 error
    '{4'd7,  4'b0000, 1'b1, 1'b0, 1'b0, 2'd1, 4'hF,    WD, 32'h0, 32'h0,         1'b0}  // R7 write
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0]  obsCyc;
  logic [3:0]  obsBe1, obsBe2;
  logic [31:0] obsWd1, obsWd2;
  logic [31:0] obsRd;
  logic        obsErr, obsDone, obsDoneAfter;

  // starts at a negedge, leaves at a negedge one clock after done
  task automatic runTxn(input logic [3:0] be, input logic wr, input logic n1, input logic n2,
                        input int waits, input logic pokeBusy);
    @(negedge clk);
    reqBeN = be; reqWrite = wr; reqWdata = WD; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    obsCyc = 0; obsBe1 = 4'hF; obsBe2 = 4'hF; obsWd1 = 0; obsWd2 = 0;
    for (int guard = 0; guard < 4 && busCycle; guard++) begin
      obsCyc++;
      if (obsCyc == 1) begin obsBe1 = busBeN; obsWd1 = busWdata; end
      else begin obsBe2 = busBeN; obsWd2 = busWdata; end
      for (int w = 0; w < waits; w++) begin
        logic [3:0]  holdBe;
        logic [31:0] holdWd;
        holdBe = busBeN; holdWd = busWdata;
        if (pokeBusy) begin reqValid = 1'b1; reqBeN = 4'b0101; end
        @(negedge clk);
        reqValid = 1'b0;
        check(busCycle && busBeN == holdBe && busWdata == holdWd, "R3 hold",
              {busBeN, busWdata[27:0]}, {holdBe, holdWd[27:0]});
      end
      busRdy    = 1'b1;
      busNarrow = (obsCyc == 1) ? n1 : n2;
      busRdata  = (obsCyc == 1) ? RD1 : RD2;
      @(negedge clk);
      busRdy = 1'b0; busNarrow = 1'b0; busRdata = 32'hDEAD_BEEF;
    end
    obsDone = doneStrobe; obsRd = rdData; obsErr = protoErr;
    @(negedge clk);
    obsDoneAfter = doneStrobe;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reqValid = 0; reqBeN = 4'hF; reqWrite = 0; reqWdata = 0;
    busRdata = 0; busRdy = 0; busNarrow = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busCycle && !doneStrobe && busBeN == 4'hF, "R1 reset", {27'h0, busCycle, busBeN}, 32'h0000_000F);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v.tag, i);
      runTxn(v.be, v.wr, v.n1, v.n2, 0, 1'b0);
      check(obsCyc == v.cyc, tg, {30'h0, obsCyc}, {30'h0, v.cyc});
      check(obsBe1 == v.be, {tg, " R2 be"}, {28'h0, obsBe1}, {28'h0, v.be});
      if (v.wr) check(obsWd1 == v.wd1, {tg, " wd1"}, obsWd1, v.wd1);
      if (v.cyc == 2) check(obsBe2 == v.be2, {tg, " R9 be2"}, {28'h0, obsBe2}, {28'h0, v.be2});
      if (v.cyc == 2 && v.wr) check(obsWd2 == v.wd2, {tg, " wd2"}, obsWd2, v.wd2);
      if (!v.wr) check(obsRd == v.rd, {tg, " rd"}, obsRd, v.rd);
      check(obsErr == v.err, {tg, " R11 err"}, {31'h0, obsErr}, {31'h0, v.err});
      check(obsDone && !obsDoneAfter, {tg, " R12 done"}, {30'h0, obsDone, obsDoneAfter}, 32'h2);
    end

    // R3 wait states on a split read, R2 request pulsed while busy is ignored
    runTxn(4'b0000, 1'b0, 1'b1, 1'b1, 3, 1'b1);
    check(obsCyc == 2 && obsRd == 32'h7788_C3D4, "R3 split with waits", obsRd, 32'h7788_C3D4);
    check(obsBe2 == 4'b0011, "R2 be unaffected by busy request", {28'h0, obsBe2}, 32'h3);
    check(!busCycle && !doneStrobe, "R2 no extra cycle", {30'h0, busCycle, doneStrobe}, 32'h0);

    // R11 error cleared by next request
    runTxn(4'b0000, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    check(obsErr, "R11 err set", {31'h0, obsErr}, 32'h1);
    runTxn(4'b1100, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    check(!obsErr, "R11 err cleared", {31'h0, obsErr}, 32'h0);

    // R1 reset in the middle of a transfer
    @(negedge clk);
    reqBeN = 4'b0000; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busCycle, "R2 cycle started", {31'h0, busCycle}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busCycle && !doneStrobe && busBeN == 4'hF, "R1 mid-transfer reset",
          {27'h0, busCycle, busBeN}, 32'h0000_000F);
    @(negedge clk);
    check(!busCycle && !doneStrobe, "R1 stays idle", {30'h0, busCycle, doneStrobe}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule